// File: doc/BRIEF.md
# Machine Timer with Privilege-Gated Time CSR Shadow

This block holds a free-running 64-bit machine timer that sits on a simple memory-mapped word bus, and the hart-side path that serves the read-only time CSRs. The timer counts up by one on each tick-enable pulse. It is read and written as two 32-bit words. The low word is at a base address given by a parameter, and the high word is at the base plus four. Both bus reads and bus writes are single-cycle.

The hart does not see the timer itself. It sees a shadow copy that passes through a parameterised number of register stages, which may be zero. Two CSR selectors give that shadow to the hart: one returns the low half and one returns the high half. A small response state machine answers every CSR request one cycle later. The request is either granted with data or trapped with an illegal-instruction flag.

Whether a read is legal depends on three things: the requesting privilege level, a machine counter-enable bit, and an optional supervisor counter-enable bit. The response machine has three states:

- CR_IDLE: no response.
- CR_GRANT: valid response with data.
- CR_TRAP: valid response with the illegal flag set and data forced to zero.

From any state, a legal request moves the machine to CR_GRANT, an illegal request moves it to CR_TRAP, and a cycle with no request moves it to CR_IDLE.

Top module: `mtimer_csr_shadow`

## Requirements
- R1: The timer increments by exactly one on each cycle where tick_en is 1 and no bus write hits it. The carry propagates from the low word into the high word.
- R2: A bus write to BASE_ADDR replaces the low word, and a bus write to BASE_ADDR+4 replaces the high word. The change is visible at the next clock, no increment happens in that cycle, and the other word is unchanged. A write to any other address leaves the timer unchanged.
- R3: bus_rdata is combinational from bus_addr: the low word at BASE_ADDR, the high word at BASE_ADDR+4, and zero at any other address.
- R4: The CSR shadow lags the timer by SHADOW_STAGES clock cycles. A read sampled N cycles after the write edge, plus one, returns the new value exactly when N >= SHADOW_STAGES.
- R5: Each cycle with csr_req=1 produces rsp_valid=1 in the following cycle. A granted read returns the low shadow word when csr_sel_hi=0 and the high shadow word when csr_sel_hi=1.
- R6: Privilege is encoded in csr_priv as 0=U, 1=S, 2=reserved, 3=M. A read from M is always granted, whatever the enable bits hold.
- R7: When S is implemented (HAS_SMODE=1), a read from S is granted only when the machine TM bit is 1. When S is not implemented, a request with csr_priv=1 is always illegal.
- R8: When HAS_SMODE=1, a read from U needs both the machine TM bit and the supervisor TM bit. When HAS_SMODE=0, a read from U needs only the machine TM bit, and writes to the supervisor enable have no effect.
- R9: Any request with csr_write=1 is illegal, and any request with csr_priv=2 is illegal.
- R10: A trapped response has rsp_illegal=1 and rsp_data=0.
- R11: Reset sets the following to zero: the timer, the shadow stages, both TM bits, and rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer increment pulse |
| bus_wr_en | input | 1 | Bus word write strobe |
| bus_addr | input | ADDR_W | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational) |
| mcen_we | input | 1 | Write strobe for machine TM bit |
| scen_we | input | 1 | Write strobe for supervisor TM bit |
| cen_wdata | input | 1 | Value written to the selected TM bit |
| csr_req | input | 1 | CSR access request |
| csr_write | input | 1 | Request is a write attempt |
| csr_sel_hi | input | 1 | 0 selects low shadow word, 1 selects high |
| csr_priv | input | 2 | Requesting privilege (0 U, 1 S, 2 reserved, 3 M) |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Illegal-instruction flag |
| rsp_data | output | 32 | Read data, zero when trapped |

## Verification
The bench sweeps every combination of the two TM bits, the four privilege codes, the two selectors and the write flag. It does this on two configurations: one with S-mode and two shadow stages, and one with neither. A gate that ignored the supervisor bit would grant U reads that should trap. A gate that treated an absent S-mode as present would grant priv=1 reads. A gate that let writes through would return data for a read-only CSR.

The bench measures the shadow lag by reading 0 to 3 cycles after a timer write. An off-by-one in the stage count would return the new value one read too early or one read too late.

Two further corner cases are exercised. One is the low-to-high carry. The other is a bus write landing in the same cycle as a tick: a design with the wrong priority would increment the value it was meant to overwrite.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        CR_IDLE  = 2'd0,
        CR_GRANT = 2'd1,
        CR_TRAP  = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/tcs_mtimer.sv
module tcs_mtimer #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h100,
    parameter int                WORD_W    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic                  bus_wr_en,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [2*WORD_W-1:0]   timer_q
);
    localparam int                TIMER_W = 2 * WORD_W;
    localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(WORD_W / 8);

    logic hit_lo, hit_hi;
    assign hit_lo = (bus_addr == BASE_ADDR);
    assign hit_hi = (bus_addr == HI_ADDR);

    // Bus writes take priority over the tick in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
        end else if (bus_wr_en && hit_lo) begin
            timer_q[WORD_W-1:0] <= bus_wdata;
        end else if (bus_wr_en && hit_hi) begin
            timer_q[TIMER_W-1:WORD_W] <= bus_wdata;
        end else if (tick_en) begin
            timer_q <= timer_q + TIMER_W'(1);
        end
    end

    always_comb begin
        if (hit_lo)      bus_rdata = timer_q[WORD_W-1:0];
        else if (hit_hi) bus_rdata = timer_q[TIMER_W-1:WORD_W];
        else             bus_rdata = '0;
    end

    // R1: a tick with no bus write adds exactly one
    p_tick_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !bus_wr_en) |=> (timer_q == $past(timer_q) + TIMER_W'(1)));

    // R2: a low-word write lands unmodified, even with a tick present
    p_write_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && hit_lo) |=> (timer_q[WORD_W-1:0] == $past(bus_wdata)));

    // R2: a high-word write leaves the low word alone
    p_write_hi_keeps_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && hit_hi) |=> (timer_q[WORD_W-1:0] == $past(timer_q[WORD_W-1:0])));

endmodule

// File: rtl/tcs_shadow.sv
module tcs_shadow #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_direct
            assign dout = din;
        end else begin : g_pipe
            logic [WIDTH-1:0] pipe [STAGES];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= din;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end

            assign dout = pipe[STAGES-1];

            // R4: the first stage holds the input from one cycle earlier
            p_first_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (pipe[0] == $past(din)));
        end
    endgenerate

endmodule

// File: rtl/tcs_csr_gate.sv
module tcs_csr_gate
    import tcs_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mcen_we,
    input  logic                scen_we,
    input  logic                cen_wdata,
    input  logic [2*WORD_W-1:0] shadow,
    input  logic                csr_req,
    input  logic                csr_write,
    input  logic                csr_sel_hi,
    input  logic [1:0]          csr_priv,
    output logic                rsp_valid,
    output logic                rsp_illegal,
    output logic [WORD_W-1:0]   rsp_data
);
    logic        m_tm_q, s_tm_q;
    logic        priv_ok, req_legal;
    priv_e       pv;
    rsp_state_e  state_q, state_d;
    logic [WORD_W-1:0] data_q;

    // Counter-enable TM bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       m_tm_q <= 1'b0;
        else if (mcen_we) m_tm_q <= cen_wdata;
    end

    generate
        if (HAS_SMODE) begin : g_scen
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       s_tm_q <= 1'b0;
                else if (scen_we) s_tm_q <= cen_wdata;
            end
        end else begin : g_no_scen
            assign s_tm_q = 1'b0;
        end
    endgenerate

    // Privilege decision
    assign pv = priv_e'(csr_priv);

    always_comb begin
        unique case (pv)
            PRIV_M:  priv_ok = 1'b1;
            PRIV_S:  priv_ok = HAS_SMODE ? m_tm_q : 1'b0;
            PRIV_U:  priv_ok = HAS_SMODE ? (m_tm_q && s_tm_q) : m_tm_q;
            default: priv_ok = 1'b0;
        endcase
    end

    assign req_legal = priv_ok && !csr_write;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CR_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (csr_req)
                data_q <= csr_sel_hi ? shadow[2*WORD_W-1:WORD_W] : shadow[WORD_W-1:0];
        end
    end

    // Next state
    always_comb begin
        if (!csr_req)       state_d = CR_IDLE;
        else if (req_legal) state_d = CR_GRANT;
        else                state_d = CR_TRAP;
    end

    // Outputs
    always_comb begin
        rsp_valid   = 1'b0;
        rsp_illegal = 1'b0;
        rsp_data    = '0;
        unique case (state_q)
            CR_GRANT: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
            end
            CR_TRAP: begin
                rsp_valid   = 1'b1;
                rsp_illegal = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: every request is answered in the next cycle
    p_rsp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        csr_req |=> rsp_valid);

    // R6: machine reads always succeed
    p_mread_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_write && csr_priv == 2'd3) |=> (rsp_valid && !rsp_illegal));

    // R7: with the machine TM bit clear, lower levels trap
    p_tm_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_priv != 2'd3 && !m_tm_q) |=> rsp_illegal);

    // R9: write attempts trap
    p_write_traps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_write) |=> rsp_illegal);

    // R10: trapped responses carry no data
    p_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (rsp_valid && rsp_data == '0));

endmodule

// File: rtl/mtimer_csr_shadow.sv
module mtimer_csr_shadow #(
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR     = 'h100,
    parameter int                SHADOW_STAGES = 2,
    parameter bit                HAS_SMODE     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              mcen_we,
    input  logic              scen_we,
    input  logic              cen_wdata,
    input  logic              csr_req,
    input  logic              csr_write,
    input  logic              csr_sel_hi,
    input  logic [1:0]        csr_priv,
    output logic              rsp_valid,
    output logic              rsp_illegal,
    output logic [31:0]       rsp_data
);
    localparam int WORD_W  = 32;
    localparam int TIMER_W = 2 * WORD_W;

    logic [TIMER_W-1:0] timer_val;
    logic [TIMER_W-1:0] shadow_val;

    tcs_mtimer #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .WORD_W   (WORD_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .bus_wr_en(bus_wr_en),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .timer_q  (timer_val)
    );

    tcs_shadow #(
        .WIDTH (TIMER_W),
        .STAGES(SHADOW_STAGES)
    ) u_shadow (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (timer_val),
        .dout (shadow_val)
    );

    tcs_csr_gate #(
        .WORD_W   (WORD_W),
        .HAS_SMODE(HAS_SMODE)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mcen_we    (mcen_we),
        .scen_we    (scen_we),
        .cen_wdata  (cen_wdata),
        .shadow     (shadow_val),
        .csr_req    (csr_req),
        .csr_write  (csr_write),
        .csr_sel_hi (csr_sel_hi),
        .csr_priv   (csr_priv),
        .rsp_valid  (rsp_valid),
        .rsp_illegal(rsp_illegal),
        .rsp_data   (rsp_data)
    );

endmodule

// File: tb/sim_mtimer_csr_shadow.sv
`timescale 1ns/1ps
module sim_mtimer_csr_shadow;
    localparam logic [15:0] BASE = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [15:0] bus_addr = BASE;
    logic [31:0] bus_wdata = '0;
    logic        mcen_we = 1'b0, scen_we = 1'b0, cen_wdata = 1'b0;
    logic        csr_req = 1'b0, csr_write = 1'b0, csr_sel_hi = 1'b0;
    logic [1:0]  csr_priv = 2'd3;

    logic [31:0] rd0, rd1, dat0, dat1;
    logic        v0, v1, il0, il1;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    mtimer_csr_shadow #(.BASE_ADDR(BASE), .SHADOW_STAGES(2), .HAS_SMODE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr_en(bus_wr_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0),
        .mcen_we(mcen_we), .scen_we(scen_we), .cen_wdata(cen_wdata),
        .csr_req(csr_req), .csr_write(csr_write), .csr_sel_hi(csr_sel_hi),
        .csr_priv(csr_priv), .rsp_valid(v0), .rsp_illegal(il0), .rsp_data(dat0));

    mtimer_csr_shadow #(.BASE_ADDR(BASE), .SHADOW_STAGES(0), .HAS_SMODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr_en(bus_wr_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1),
        .mcen_we(mcen_we), .scen_we(scen_we), .cen_wdata(cen_wdata),
        .csr_req(csr_req), .csr_write(csr_write), .csr_sel_hi(csr_sel_hi),
        .csr_priv(csr_priv), .rsp_valid(v1), .rsp_illegal(il1), .rsp_data(dat1));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_ok(int p, bit mt, bit st, bit wr, bit has_s);
        if (wr) return 1'b0;
        case (p)
            3: return 1'b1;
            1: return has_s ? mt : 1'b0;
            0: return has_s ? (mt && st) : mt;
            default: return 1'b0;
        endcase
    endfunction

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input bit tick);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1; tick_en = tick;
        @(negedge clk);
        bus_wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic read_both(output logic [31:0] lo, output logic [31:0] hi);
        bus_addr = BASE;        #0.5; lo = rd0;
        bus_addr = BASE + 16'd4; #0.5; hi = rd0;
    endtask

    task automatic set_cen(input bit mt, input bit st);
        mcen_we = 1'b1; scen_we = 1'b1;
        cen_wdata = mt; scen_we = 1'b0;
        @(negedge clk);
        mcen_we = 1'b0; scen_we = 1'b1; cen_wdata = st;
        @(negedge clk);
        scen_we = 1'b0;
    endtask

    // Request at a negedge; response sampled just after the next posedge
    task automatic csr_access(input int p, input bit hi, input bit wr);
        csr_req = 1'b1; csr_priv = 2'(p); csr_sel_hi = hi; csr_write = wr;
        @(posedge clk); #1;
    endtask

    task automatic csr_release;
        @(negedge clk);
        csr_req = 1'b0; csr_write = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] lo, hi;
        logic [31:0] old_lo, new_lo;
        repeat (3) @(negedge clk);

        // R11: reset state
        chk(v0 == 1'b0 && v1 == 1'b0, "R11 rsp_valid in reset", {62'd0, v0, v1}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_both(lo, hi);
        chk(lo == 0 && hi == 0, "R11 timer zero", {hi, lo}, 64'd0);
        csr_access(0, 1'b0, 1'b0);
        chk(v0 && il0, "R11 TM bits clear so U traps", {62'd0, v0, il0}, 64'd3);
        csr_release();

        // R2/R3: writes and decode
        bus_write(BASE, 32'hFFFF_FFFE, 1'b0);
        bus_write(BASE + 16'd4, 32'h0000_0005, 1'b0);
        read_both(lo, hi);
        chk(lo == 32'hFFFF_FFFE && hi == 32'd5, "R2 word writes", {hi, lo}, 64'h5_FFFF_FFFE);
        chk(rd1 == 32'd5, "R3 high word on second instance", {32'd0, rd1}, 64'd5);
        bus_addr = 16'h0108; #0.5;
        chk(rd0 == 0, "R3 other address reads zero", {32'd0, rd0}, 64'd0);
        bus_addr = 16'h0101; #0.5;
        chk(rd0 == 0, "R3 unaligned address reads zero", {32'd0, rd0}, 64'd0);

        // R1: carry into the high word
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        read_both(lo, hi);
        chk(lo == 32'd1 && hi == 32'd6, "R1 three ticks with carry", {hi, lo}, 64'h6_0000_0001);

        // R2: write beats a simultaneous tick
        bus_write(BASE, 32'h0000_1234, 1'b1);
        read_both(lo, hi);
        chk(lo == 32'h1234 && hi == 32'd6, "R2 write priority over tick", {hi, lo}, 64'h6_0000_1234);
        bus_write(16'h0200, 32'hDEAD_BEEF, 1'b0);
        read_both(lo, hi);
        chk(lo == 32'h1234 && hi == 32'd6, "R2 miss write ignored", {hi, lo}, 64'h6_0000_1234);

        // R4: shadow lag
        old_lo = 32'h1234;
        for (int n = 0; n < 4; n++) begin
            repeat (4) @(negedge clk);
            new_lo = 32'h00A0 + 32'(n);
            bus_write(BASE, new_lo, 1'b0);
            repeat (n) @(negedge clk);
            csr_access(3, 1'b0, 1'b0);
            chk(dat0 == ((n >= 2) ? new_lo : old_lo), "R4 two-stage lag", {32'd0, dat0},
                {32'd0, (n >= 2) ? new_lo : old_lo});
            chk(dat1 == new_lo, "R4 zero-stage shadow", {32'd0, dat1}, {32'd0, new_lo});
            csr_release();
            old_lo = new_lo;
        end
        bus_write(BASE, 32'h0000_1234, 1'b0);
        repeat (4) @(negedge clk);

        // R5..R10: exhaustive permission sweep on both configurations
        for (int mt = 0; mt < 2; mt++) begin
            for (int st = 0; st < 2; st++) begin
                set_cen(1'(mt), 1'(st));
                for (int p = 0; p < 4; p++) begin
                    for (int h = 0; h < 2; h++) begin
                        for (int w = 0; w < 2; w++) begin
                            bit ok0, ok1;
                            logic [31:0] ed;
                            ok0 = exp_ok(p, 1'(mt), 1'(st), 1'(w), 1'b1);
                            ok1 = exp_ok(p, 1'(mt), 1'(st), 1'(w), 1'b0);
                            ed = h ? 32'd6 : 32'h1234;
                            csr_access(p, 1'(h), 1'(w));
                            chk(v0 && v1, "R5 response valid", {62'd0, v0, v1}, 64'd3);
                            // R6 R7 R8 R9: legality per privilege
                            chk(il0 == !ok0, "R7 R8 R9 legality with S-mode",
                                {63'd0, il0}, {63'd0, !ok0});
                            chk(il1 == !ok1, "R7 R8 R9 legality without S-mode",
                                {63'd0, il1}, {63'd0, !ok1});
                            // R5 data on grant, R10 zero on trap
                            chk(dat0 == (ok0 ? ed : 32'd0), "R5 R10 data with S-mode",
                                {32'd0, dat0}, {32'd0, ok0 ? ed : 32'd0});
                            chk(dat1 == (ok1 ? ed : 32'd0), "R5 R10 data without S-mode",
                                {32'd0, dat1}, {32'd0, ok1 ? ed : 32'd0});
                            csr_release();
                        end
                    end
                end
            end
        end

        // R6: M read with all enables cleared
        set_cen(1'b0, 1'b0);
        csr_access(3, 1'b1, 1'b0);
        chk(!il0 && dat0 == 32'd6, "R6 M read with TM clear", {31'd0, il0, dat0}, 64'd6);
        csr_release();
        @(negedge clk);
        chk(!v0 && !v1, "R5 idle after request ends", {62'd0, v0, v1}, 64'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule